// File: doc/BRIEF.md
# Timer with Compare Waveform Output

An up-counting timer with one compare channel that drives a single waveform pin. Each cycle in which the count-enable input is high is one timer tick. On a tick the counter either advances or, in clear-on-match mode, returns to zero when it equals the compare register. This lets the compare value set the period of the count. A sticky overflow flag and a sticky compare flag record events until an acknowledge input clears them.

Software writes the counter, the compare value, the mode field and the compare-output action field through simple write-enable and data port pairs. The action field chooses what a compare match does to the pin state: nothing, toggle, clear or set. A force strobe applies the current action at once, without a match. The pin state can be preloaded while the output is disabled, so the pin shows a known level from the moment it is enabled.

Top module: `cmp_wave_timer`

## Requirements
- R1: After reset the counter, the compare register, the mode field, the action field, the pin state and both flags are zero, and `wave_o` is low.
- R2: Outside clear-on-match mode, a tick adds one to the counter and 0xFF rolls over to 0x00. Without a tick or a write the counter holds its value.
- R3: `ovf_flag_o` rises on the tick that moves the counter from 0xFF to 0x00. It stays high until a cycle with `ovf_ack_i` high and no new overflow. When an overflow and an acknowledge arrive in the same cycle, the flag is set.
- R4: Mode code 2 is clear-on-match: on a tick where the counter equals the compare register, the counter becomes 0x00. Mode codes 0, 1 and 3 count as in R2 and never clear on a match.
- R5: A compare match is a tick, with no counter write, on which the counter value before the tick equals the compare register. A match sets `cmp_flag_o`, which stays high until acknowledged, and a match wins over an acknowledge in the same cycle.
- R6: On a match the pin state follows the action code: 0 leaves it, 1 toggles it, 2 drives it to 0, 3 drives it to 1.
- R7: A match in the same cycle as an action-field write uses the previous action code. The new code applies from the next match.
- R8: `force_i` applies the current action code to the pin state at the next clock edge. It does not set `cmp_flag_o` and does not change the counter in any mode.
- R9: `pin_we_i` loads `pin_wdata_i` into the pin state and overrides a match or force in the same cycle. `wave_o` shows the pin state while `out_en_i` is high and is 0 otherwise, with no delay.
- R10: A counter write takes effect at the next edge in any mode and has priority over a tick. It suppresses any compare match in that cycle, so no flag is set and no pin action is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 8 | Counter write value |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | 8 | Compare write value |
| mode_we_i | input | 1 | Mode field write strobe |
| mode_wdata_i | input | 2 | Mode code (2 = clear on match) |
| act_we_i | input | 1 | Action field write strobe |
| act_wdata_i | input | 2 | Action code (0 none, 1 toggle, 2 clear, 3 set) |
| force_i | input | 1 | Apply action immediately |
| pin_we_i | input | 1 | Pin state preset strobe |
| pin_wdata_i | input | 1 | Pin state preset value |
| out_en_i | input | 1 | Drive pin state onto wave_o |
| ovf_ack_i | input | 1 | Clear overflow flag |
| cmp_ack_i | input | 1 | Clear compare flag |
| cnt_o | output | 8 | Current counter value |
| wave_o | output | 1 | Waveform output |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare-match flag |

## Verification
A wrong counter value shows on `cnt_o` one edge after the faulty tick. In clear-on-match mode it also shifts every later match, so a compare value off by one moves each pin edge by one tick. A stale or wrongly applied action code shows only at the next match or force, as a wrong `wave_o` level one edge later. Flag faults show as a missing or stray flag in the cycle after a wrap or match, or as a flag that drops without an acknowledge.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } act_e;

  localparam logic [1:0] MODE_CLR_ON_MATCH = 2'd2;
  localparam int unsigned FLAG_OVF = 0;
  localparam int unsigned FLAG_CMP = 1;
  localparam int unsigned NUM_FLAGS = 2;
endpackage

// File: rtl/cwt_counter.sv
module cwt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_on_match_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         advance;

  // a software write owns the tick: no advance, no match
  assign advance = tick_i & ~wr_i;
  assign match_o = advance & (cnt_q == cmp_i);
  assign wrap_o  = advance & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (wr_i)                      cnt_q <= wdata_i;
    else if (match_o && clr_on_match_i) cnt_q <= '0;
    else if (advance)                   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cwt_wave.sv
module cwt_wave
  import cwt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_we_i,
  input  logic [1:0] act_wdata_i,
  input  logic       match_i,
  input  logic       force_i,
  input  logic       pin_we_i,
  input  logic       pin_wdata_i,
  input  logic       out_en_i,
  output logic       pin_o,
  output logic       wave_o
);
  act_e act_q;
  logic pin_q;
  logic pin_act;

  always_comb begin
    unique case (act_q)
      ACT_TOGGLE: pin_act = ~pin_q;
      ACT_CLEAR:  pin_act = 1'b0;
      ACT_SET:    pin_act = 1'b1;
      default:    pin_act = pin_q;
    endcase
  end

  // action register is read before it is rewritten: new code applies to the next event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       act_q <= ACT_HOLD;
    else if (act_we_i) act_q <= act_e'(act_wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pin_q <= 1'b0;
    else if (pin_we_i)           pin_q <= pin_wdata_i;
    else if (match_i || force_i) pin_q <= pin_act;
  end

  assign pin_o  = pin_q;
  assign wave_o = out_en_i & pin_q;
endmodule

// File: rtl/cwt_flags.sv
module cwt_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= set_i[g] | (flag_q & ~ack_i[g]);
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/cmp_wave_timer.sv
module cmp_wave_timer
  import cwt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         cmp_we_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic         mode_we_i,
  input  logic [1:0]   mode_wdata_i,
  input  logic         act_we_i,
  input  logic [1:0]   act_wdata_i,
  input  logic         force_i,
  input  logic         pin_we_i,
  input  logic         pin_wdata_i,
  input  logic         out_en_i,
  input  logic         ovf_ack_i,
  input  logic         cmp_ack_i,
  output logic [W-1:0] cnt_o,
  output logic         wave_o,
  output logic         ovf_flag_o,
  output logic         cmp_flag_o
);
  logic [W-1:0]         cmp_q;
  logic [1:0]           mode_q;
  logic                 match;
  logic                 wrap;
  logic                 pin_q;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_ack;
  logic [NUM_FLAGS-1:0] flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      mode_q <= '0;
    end else begin
      if (cmp_we_i)  cmp_q  <= cmp_wdata_i;
      if (mode_we_i) mode_q <= mode_wdata_i;
    end
  end

  cwt_counter #(.W(W)) u_counter (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick_i),
    .clr_on_match_i (mode_q == MODE_CLR_ON_MATCH),
    .wr_i           (cnt_we_i),
    .wdata_i        (cnt_wdata_i),
    .cmp_i          (cmp_q),
    .cnt_o          (cnt_o),
    .match_o        (match),
    .wrap_o         (wrap)
  );

  cwt_wave u_wave (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_we_i    (act_we_i),
    .act_wdata_i (act_wdata_i),
    .match_i     (match),
    .force_i     (force_i),
    .pin_we_i    (pin_we_i),
    .pin_wdata_i (pin_wdata_i),
    .out_en_i    (out_en_i),
    .pin_o       (pin_q),
    .wave_o      (wave_o)
  );

  always_comb begin
    flag_set           = '0;
    flag_ack           = '0;
    flag_set[FLAG_OVF] = wrap;
    flag_set[FLAG_CMP] = match;
    flag_ack[FLAG_OVF] = ovf_ack_i;
    flag_ack[FLAG_CMP] = cmp_ack_i;
  end

  cwt_flags #(.N(NUM_FLAGS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .ack_i  (flag_ack),
    .flag_o (flags)
  );

  assign ovf_flag_o = flags[FLAG_OVF];
  assign cmp_flag_o = flags[FLAG_CMP];
endmodule

// File: rtl/cwt_checker.sv
module cwt_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         cnt_we_i,
  input logic [W-1:0] cnt_wdata_i,
  input logic [W-1:0] cmp_q,
  input logic [1:0]   mode_q,
  input logic         pin_q,
  input logic         pin_we_i,
  input logic         pin_wdata_i,
  input logic         out_en_i,
  input logic         ovf_ack_i,
  input logic         cmp_ack_i,
  input logic [W-1:0] cnt_o,
  input logic         wave_o,
  input logic         ovf_flag_o,
  input logic         cmp_flag_o
);
  logic adv;
  logic hit;
  assign adv = tick_i & ~cnt_we_i;
  assign hit = adv & (cnt_o == cmp_q);

  assert_count_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && !(hit && mode_q == 2'd2) |=> cnt_o == W'($past(cnt_o) + 1'b1));

  assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !cnt_we_i |=> $stable(cnt_o));

  assert_ovf_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && cnt_o == {W{1'b1}} |=> ovf_flag_o);

  assert_ovf_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_flag_o && !ovf_ack_i |=> ovf_flag_o);

  assert_match_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && mode_q == 2'd2 |=> cnt_o == '0);

  assert_match_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> cmp_flag_o);

  assert_cmp_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_flag_o && !cmp_ack_i |=> cmp_flag_o);

  assert_preset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_we_i |=> pin_q == $past(pin_wdata_i));

  assert_wave_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> !wave_o);

  assert_cnt_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(cnt_wdata_i));
endmodule

bind cmp_wave_timer cwt_checker #(.W(W)) u_chk (.*);

// File: tb/cmp_wave_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_wave_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 0, cnt_we_i = 0, cmp_we_i = 0, mode_we_i = 0, act_we_i = 0;
  logic [7:0] cnt_wdata_i = 0, cmp_wdata_i = 0;
  logic [1:0] mode_wdata_i = 0, act_wdata_i = 0;
  logic       force_i = 0, pin_we_i = 0, pin_wdata_i = 0, out_en_i = 0;
  logic       ovf_ack_i = 0, cmp_ack_i = 0;
  logic [7:0] cnt_o;
  logic       wave_o, ovf_flag_o, cmp_flag_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  cmp_wave_timer dut_i (.*);

  // {tick, expected cnt, expected wave, expected cmp flag}; cmp=2, clear-on-match, toggle
  localparam logic [10:0] VECS [0:6] = '{
    {1'b1, 8'd1, 1'b0, 1'b0},
    {1'b1, 8'd2, 1'b0, 1'b0},
    {1'b1, 8'd0, 1'b1, 1'b1},
    {1'b0, 8'd0, 1'b1, 1'b1},
    {1'b1, 8'd1, 1'b1, 1'b1},
    {1'b1, 8'd2, 1'b1, 1'b1},
    {1'b1, 8'd0, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
    tick_i = 0; cnt_we_i = 0; cmp_we_i = 0; mode_we_i = 0; act_we_i = 0;
    force_i = 0; pin_we_i = 0; ovf_ack_i = 0; cmp_ack_i = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 cnt", cnt_o, 8'h00);
    chk("R1 ovf", {7'b0, ovf_flag_o}, 8'h0);
    chk("R1 cmp flag", {7'b0, cmp_flag_o}, 8'h0);
    chk("R1 wave", {7'b0, wave_o}, 8'h0);
    rst_ni = 1'b1;
    out_en_i = 1'b1;
    #1;
    chk("R1 pin state", {7'b0, wave_o}, 8'h0);

    cmp_we_i = 1; cmp_wdata_i = 8'd2; mode_we_i = 1; mode_wdata_i = 2'd2;
    act_we_i = 1; act_wdata_i = 2'd1; pin_we_i = 1; pin_wdata_i = 0;
    cnt_we_i = 1; cnt_wdata_i = 0; ovf_ack_i = 1; cmp_ack_i = 1;
    cyc();
    for (int i = 0; i < 7; i++) begin
      tick_i = VECS[i][10];
      cyc();
      chk("R4 vec cnt", cnt_o, VECS[i][9:2]);
      chk("R6 vec wave", {7'b0, wave_o}, {7'b0, VECS[i][1]});
      chk("R5 vec flag", {7'b0, cmp_flag_o}, {7'b0, VECS[i][0]});
    end

    mode_we_i = 1; mode_wdata_i = 0; cnt_we_i = 1; cnt_wdata_i = 8'hFE;
    cmp_we_i = 1; cmp_wdata_i = 8'h80; cmp_ack_i = 1;
    cyc();
    chk("R10 write", cnt_o, 8'hFE);
    tick_i = 1; cyc();
    chk("R2 to FF", cnt_o, 8'hFF);
    chk("R3 no ovf yet", {7'b0, ovf_flag_o}, 8'h0);
    tick_i = 1; cyc();
    chk("R2 wrap", cnt_o, 8'h00);
    chk("R3 ovf set", {7'b0, ovf_flag_o}, 8'h1);
    cyc();
    chk("R2 hold", cnt_o, 8'h00);
    chk("R3 sticky", {7'b0, ovf_flag_o}, 8'h1);
    ovf_ack_i = 1; cyc();
    chk("R3 ack", {7'b0, ovf_flag_o}, 8'h0);
    cnt_we_i = 1; cnt_wdata_i = 8'hFF; cyc();
    tick_i = 1; ovf_ack_i = 1; cyc();
    chk("R3 set wins", {7'b0, ovf_flag_o}, 8'h1);

    cmp_we_i = 1; cmp_wdata_i = 8'd5; cnt_we_i = 1; cnt_wdata_i = 8'd5;
    act_we_i = 1; act_wdata_i = 2'd0; ovf_ack_i = 1; cmp_ack_i = 1;
    cyc();
    tick_i = 1; cyc();
    chk("R4 mode0 no clear", cnt_o, 8'd6);
    chk("R5 match flag", {7'b0, cmp_flag_o}, 8'h1);
    chk("R6 hold code", {7'b0, wave_o}, 8'h0);

    cmp_ack_i = 1; cyc();
    chk("R5 ack", {7'b0, cmp_flag_o}, 8'h0);
    cnt_we_i = 1; cnt_wdata_i = 8'd5; cyc();
    tick_i = 1; cnt_we_i = 1; cnt_wdata_i = 8'd5; cyc();
    chk("R10 write wins tick", cnt_o, 8'd5);
    chk("R10 match blocked", {7'b0, cmp_flag_o}, 8'h0);

    tick_i = 1; act_we_i = 1; act_wdata_i = 2'd3; cyc();
    chk("R7 old code used", {7'b0, wave_o}, 8'h0);
    chk("R7 cnt", cnt_o, 8'd6);
    cnt_we_i = 1; cnt_wdata_i = 8'd5; cyc();
    tick_i = 1; cyc();
    chk("R7 new code next match", {7'b0, wave_o}, 8'h1);

    act_we_i = 1; act_wdata_i = 2'd2; cmp_ack_i = 1; cyc();
    force_i = 1; cyc();
    chk("R8 force clear", {7'b0, wave_o}, 8'h0);
    chk("R8 cnt kept", cnt_o, 8'd6);
    chk("R8 no flag", {7'b0, cmp_flag_o}, 8'h0);
    mode_we_i = 1; mode_wdata_i = 2'd2; act_we_i = 1; act_wdata_i = 2'd1; cyc();
    force_i = 1; cyc();
    chk("R8 force toggle", {7'b0, wave_o}, 8'h1);
    chk("R8 no clear in mode 2", cnt_o, 8'd6);

    act_we_i = 1; act_wdata_i = 2'd2; cmp_we_i = 1; cmp_wdata_i = 8'd6; cyc();
    tick_i = 1; cyc();
    chk("R4 clear on match", cnt_o, 8'd0);
    chk("R6 clear code", {7'b0, wave_o}, 8'h0);

    pin_we_i = 1; pin_wdata_i = 1; force_i = 1; cyc();
    chk("R9 preset beats force", {7'b0, wave_o}, 8'h1);
    out_en_i = 0; #1;
    chk("R9 gated", {7'b0, wave_o}, 8'h0);
    pin_we_i = 1; pin_wdata_i = 0; cyc();
    pin_we_i = 1; pin_wdata_i = 1; cyc();
    chk("R9 preset while disabled", {7'b0, wave_o}, 8'h0);
    out_en_i = 1; #1;
    chk("R9 enable shows preset", {7'b0, wave_o}, 8'h1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule